// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block lets an on-chip master read and write single bytes of an external 64K x 8 static RAM. The pins are shared: one 8-bit bidirectional port carries the low address byte first and the data byte afterwards. A second 8-bit output port carries the high address byte for the whole access. An address-latch-enable output (`ale`) controls an external transparent latch, which holds the low address byte once `ale` goes low. Active-low read (`rd_n`) and write (`wr_n`) strobes control the memory.

The master uses a request/acknowledge handshake. It presents `req_valid` with a 16-bit address, a direction flag, write data and three phase-length fields. The controller accepts the request only when idle and runs one access at a time. When the access ends it raises `ack` for one cycle, and for a read it presents the byte on `rdata` at the same time. The shared port is modelled as a separate input, output and output-enable, so the pad ring can build the tristate buffer.

The sequencer has six named states:
- `ST_IDLE`: waits for a request.
- `ST_ADDR`: drives `ale` high with the low address on the shared port.
- `ST_HOLD`: one cycle with `ale` low that keeps the low address on the port.
- `ST_SETUP`: the port turns to write data, or to high impedance for a read; strobes stay high.
- `ST_STROBE`: the strobe for the access direction is low.
- `ST_DONE`: the acknowledge cycle.

The transitions are:
- IDLE→ADDR when a request is present.
- ADDR→HOLD when the address count expires.
- HOLD→SETUP always.
- SETUP→STROBE when the setup count expires.
- STROBE→DONE when the pulse count expires.
- DONE→IDLE always.

Top module: `membus_mux_ctrl`

## Requirements
- R1: After a synchronous active-high `rst`, and whenever no access is in progress, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0 and `ack`=0.
- R2: An accepted access first holds `ale`=1 for exactly `cfg_addr_cyc`+1 cycles. During that time `ad_oe`=1 and `ad_out` = address bits 7:0. `a_hi` shows address bits 15:8 for the whole access.
- R3: In the first cycle after `ale` falls, `ad_oe` stays 1 and `ad_out` still carries address bits 7:0.
- R4: After that hold cycle, both strobes stay high for exactly `cfg_setup_cyc`+1 cycles before any strobe is asserted. A strobe is never low while `ale` is high.
- R5: The strobe for the access direction (`req_write`=1 write, 0 read) stays low for exactly `cfg_strobe_cyc`+1 cycles. The other strobe stays high, so the two are never low together.
- R6: For a write, `ad_oe`=1 and `ad_out` = write data throughout the setup and strobe phases.
- R7: For a read, `ad_oe`=0 throughout the setup and strobe phases. `rdata` takes the value of `ad_in` in the last cycle that `rd_n` is low.
- R8: `ack` is high for exactly one cycle: the cycle right after the strobe returns high. For a read, `rdata` is valid in that cycle.
- R9: A request is taken only from `ST_IDLE`. Requests and changes to the phase-length fields while an access is in progress do not affect it: lengths and address are captured when the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, sampled only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| cfg_addr_cyc | input | 2 | Address phase length minus one |
| cfg_setup_cyc | input | 2 | Strobe setup length minus one |
| cfg_strobe_cyc | input | 2 | Strobe pulse width minus one |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with `ack` |
| ad_in | input | 8 | Shared port, value seen at the pins |
| ad_out | output | 8 | Shared port, value driven |
| ad_oe | output | 1 | Shared port output enable |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench connects a behavioural RAM with a transparent latch and counts every phase length with the extreme settings 0 and 3 in several combinations. A controller that released the shared port in the same cycle that `ale` falls would feed the latch a changing address, and the RAM model would then store or return the wrong byte. A controller with an off-by-one phase count, or one that sampled read data after the strobe rose, would show a length or data mismatch. Requests and phase-length changes issued during an access must produce neither a second `ale` pulse nor a change in the running access's timing, which a controller that samples its inputs outside idle would fail.

// File: rtl/membus_pkg.sv
package membus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_SETUP,
        ST_STROBE,
        ST_DONE
    } bus_state_t;
endpackage

// File: rtl/membus_phase_timer.sv
module membus_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/membus_pad_ctrl.sv
module membus_pad_ctrl
    import membus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_state_t        state,
    input  logic              is_write,
    input  logic [DATA_W-1:0] addr_lo,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n
);
    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        unique case (state)
            ST_IDLE: begin
            end
            ST_ADDR: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = addr_lo;
            end
            ST_HOLD: begin
                ad_oe  = 1'b1;
                ad_out = addr_lo;
            end
            ST_SETUP: begin
                ad_oe  = is_write;
                ad_out = is_write ? wdata : '0;
            end
            ST_STROBE: begin
                ad_oe  = is_write;
                ad_out = is_write ? wdata : '0;
                wr_n   = !is_write;
                rd_n   = is_write;
            end
            ST_DONE: begin
            end
            default: begin
            end
        endcase
    end

    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    assert_strobe_after_ale_R4: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !ale);

    assert_read_release_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    assert_write_drive_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe && ad_out == wdata);
endmodule

// File: rtl/membus_read_capture.sv
module membus_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= ad_in;
        end
    end
endmodule

// File: rtl/membus_mux_ctrl.sv
module membus_mux_ctrl
    import membus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [CNT_W-1:0]         cfg_addr_cyc,
    input  logic [CNT_W-1:0]         cfg_setup_cyc,
    input  logic [CNT_W-1:0]         cfg_strobe_cyc,
    output logic                     ack,
    output logic [DATA_W-1:0]        rdata,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n
);
    localparam int HI_W = ADDR_W - DATA_W;

    bus_state_t        state_q, state_d;
    logic              acc_write_q;
    logic [ADDR_W-1:0] acc_addr_q;
    logic [DATA_W-1:0] acc_wdata_q;
    logic [CNT_W-1:0]  cfg_setup_q, cfg_strobe_q;
    logic              accept;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    logic              capture;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // request capture, only from idle
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_write_q  <= 1'b0;
            acc_addr_q   <= '0;
            acc_wdata_q  <= '0;
            cfg_setup_q  <= '0;
            cfg_strobe_q <= '0;
        end else if (accept) begin
            acc_write_q  <= req_write;
            acc_addr_q   <= req_addr;
            acc_wdata_q  <= req_wdata;
            cfg_setup_q  <= cfg_setup_cyc;
            cfg_strobe_q <= cfg_strobe_cyc;
        end
    end

    // next state and timer control
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = cfg_addr_cyc;
                    state_d  = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (tmr_expired) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                tmr_load = 1'b1;
                tmr_val  = cfg_setup_q;
                state_d  = ST_SETUP;
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    tmr_val  = cfg_strobe_q;
                    state_d  = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (tmr_expired) begin
                    capture = !acc_write_q;
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    membus_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    membus_pad_ctrl #(.DATA_W(DATA_W)) u_pad (
        .clk      (clk),
        .rst      (rst),
        .state    (state_q),
        .is_write (acc_write_q),
        .addr_lo  (acc_addr_q[DATA_W-1:0]),
        .wdata    (acc_wdata_q),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n)
    );

    membus_read_capture #(.DATA_W(DATA_W)) u_rcap (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .ad_in   (ad_in),
        .rdata   (rdata)
    );

    assign ack  = (state_q == ST_DONE);
    assign a_hi = acc_addr_q[ADDR_W-1:DATA_W];

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !ale && rd_n && wr_n && !ad_oe && !ack);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(ale) |-> ad_oe && ad_out == $past(ad_out));

    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    assert_ack_after_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        ack |-> rd_n && wr_n && (!$past(rd_n) || !$past(wr_n)));

    assert_busy_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) && ($past(state_q) != ST_IDLE) |-> $stable(a_hi));
endmodule

// File: tb/membus_mux_ctrl_test.sv
`timescale 1ns/1ps
module membus_mux_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [1:0] cfg_addr_cyc = '0, cfg_setup_cyc = '0, cfg_strobe_cyc = '0;
    logic       ack;
    logic [7:0] rdata;
    logic [7:0] ad_in = 8'hEE;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic [7:0] a_hi;
    logic       ale, rd_n, wr_n;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit        wr;
        logic [15:0] addr;
        logic [7:0]  data;
        int        na, ns, np;
    } item_t;
    item_t exp_q[$];

    logic [7:0] sram [int];
    logic [7:0] ref_mem [int];
    logic [7:0] latch_q = '0;

    always #2.5 clk = ~clk;

    membus_mux_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_addr_cyc(cfg_addr_cyc),
        .cfg_setup_cyc(cfg_setup_cyc), .cfg_strobe_cyc(cfg_strobe_cyc),
        .ack(ack), .rdata(rdata), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .a_hi(a_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    function automatic logic [7:0] fill(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // external RAM with transparent latch, evaluated between clock edges
    always @(negedge clk) begin
        logic [15:0] a;
        if (ale) latch_q = ad_out;
        a = {a_hi, latch_q};
        if (!wr_n && ad_oe) sram[int'(a)] = ad_out;
        if (!rd_n) ad_in <= sram.exists(int'(a)) ? sram[int'(a)] : fill(a);
        else ad_in <= 8'hEE;
    end

    // monitor / scoreboard
    initial begin
        forever begin
            item_t it;
            int n, s, p;
            @(negedge clk);
            if (rst || !ale) continue;
            if (exp_q.size() == 0) begin
                chk(0, "R9", "unexpected access start", 1, 0);
                continue;
            end
            it = exp_q[0];
            chk(a_hi == it.addr[15:8], "R2", "a_hi", a_hi, it.addr[15:8]);
            chk(ad_oe && ad_out == it.addr[7:0], "R2", "low address", ad_out, it.addr[7:0]);
            n = 0;
            while (ale && n < 20) begin n++; @(negedge clk); end
            chk(n == it.na, "R2", "ale cycles", n, it.na);
            chk(ad_oe && ad_out == it.addr[7:0], "R3", "address hold", ad_out, it.addr[7:0]);
            chk(rd_n && wr_n, "R4", "strobe in hold", {rd_n, wr_n}, 2'b11);
            @(negedge clk);
            s = 0;
            while (rd_n && wr_n && !ack && s < 20) begin
                if (it.wr) chk(ad_oe && ad_out == it.data, "R6", "setup data", ad_out, it.data);
                else chk(!ad_oe, "R7", "setup release", ad_oe, 0);
                s++; @(negedge clk);
            end
            chk(s == it.ns, "R4", "setup cycles", s, it.ns);
            chk(it.wr ? (!wr_n && rd_n) : (!rd_n && wr_n), "R5", "strobe select",
                {rd_n, wr_n}, it.wr ? 2'b10 : 2'b01);
            p = 0;
            while ((!rd_n || !wr_n) && p < 20) begin
                if (it.wr) chk(ad_oe && ad_out == it.data, "R6", "strobe data", ad_out, it.data);
                else chk(!ad_oe, "R7", "strobe release", ad_oe, 0);
                p++; @(negedge clk);
            end
            chk(p == it.np, "R5", "strobe cycles", p, it.np);
            chk(ack == 1'b1, "R8", "ack after strobe", ack, 1);
            if (!it.wr) chk(rdata == it.data, "R7", "read data", rdata, it.data);
            void'(exp_q.pop_front());
            @(negedge clk);
            chk(ack == 1'b0, "R8", "ack single cycle", ack, 0);
            chk(!ale && rd_n && wr_n && !ad_oe, "R1", "idle after access", ad_oe, 0);
        end
    end

    task automatic access(input bit wr, input logic [15:0] addr, input logic [7:0] data,
                          input logic [1:0] ca, input logic [1:0] cs, input logic [1:0] cp,
                          input bit poke);
        item_t it;
        int g;
        it.wr = wr; it.addr = addr; it.na = ca + 1; it.ns = cs + 1; it.np = cp + 1;
        if (wr) begin
            ref_mem[int'(addr)] = data;
            it.data = data;
        end else begin
            it.data = ref_mem.exists(int'(addr)) ? ref_mem[int'(addr)] : fill(addr);
        end
        exp_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
        cfg_addr_cyc = ca; cfg_setup_cyc = cs; cfg_strobe_cyc = cp;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            // R9: busy-time request and config change must be ignored
            @(negedge clk);
            req_valid = 1'b1; req_write = !wr; req_addr = ~addr;
            cfg_addr_cyc = ~ca; cfg_setup_cyc = ~cs; cfg_strobe_cyc = ~cp;
            @(negedge clk);
            req_valid = 1'b0;
        end
        g = 0;
        while (!ack && g < 50) begin @(negedge clk); g++; end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!ale, "R1", "ale after reset", ale, 0);
        chk(rd_n && wr_n, "R1", "strobes after reset", {rd_n, wr_n}, 2'b11);
        chk(!ad_oe && !ack, "R1", "port/ack after reset", {ad_oe, ack}, 0);

        access(1, 16'h12A5, 8'h5A, 2'd0, 2'd0, 2'd0, 0);
        access(0, 16'h12A5, 8'h00, 2'd3, 2'd3, 2'd3, 0);
        access(1, 16'hFF00, 8'hC3, 2'd3, 2'd0, 2'd2, 0);
        access(0, 16'hFF00, 8'h00, 2'd1, 2'd2, 2'd0, 0);
        access(0, 16'h0F0F, 8'h00, 2'd2, 2'd1, 2'd1, 0);
        access(1, 16'h8001, 8'h77, 2'd1, 2'd1, 2'd3, 1);
        access(0, 16'h8001, 8'h00, 2'd0, 2'd3, 2'd1, 1);
        access(1, 16'h0000, 8'hFF, 2'd2, 2'd2, 2'd2, 0);
        access(0, 16'h0000, 8'h00, 2'd0, 2'd0, 2'd0, 0);

        // R9: ignored busy-time requests leave nothing behind
        repeat (6) begin
            @(negedge clk);
            chk(!ale && !ack, "R9", "no extra access", ale, 0);
        end
        chk(exp_q.size() == 0, "R8", "all accesses acknowledged", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule